// File: doc/BRIEF.md
# Flash Write Status Generator

This block builds the byte a flash device returns when the host reads it while an embedded byte program or sector erase is running, or while an erase is suspended. It keeps two toggle flip-flops: an activity toggle that flips on every status read while an operation is active, and a sector toggle that flips only on reads that land in a sector marked for erase. The other status bits are formed from the datum being programmed, the overrun (timeout) flag and the erase-load-window flag.

The surrounding controller supplies the operating mode, the mask of erasing sectors and a one-cycle start pulse at the beginning of each operation. On every read strobe the block registers a new status byte together with a pass-through flag. When that flag is set, the controller returns array data instead of the status byte. Between strobes both outputs hold their values.

Top module: `flash_wstat`

## Requirements
- R1: After reset `stat_o` is 8'h00, `array_sel_o` is 0, and both toggles are 0.
- R2: In mode 1 (program) a read returns bit 7 = inverted `prog_data_i[7]` and bit 6 = the activity toggle, which then flips at any sector; bit 2 shows the sector toggle, which does not advance.
- R3: In mode 2 (erase) a read returns bit 7 = 0 and bit 6 = the activity toggle, which flips on every read; the sector toggle (bit 2) flips only when `erase_mask_i[rd_sector_i]` is 1.
- R4: In modes 1, 2 and 4, bit 5 equals `timeout_i`; in every other mode bit 5 is 0.
- R5: In mode 2, bit 3 is the inverse of `win_open_i`; in every other mode bit 3 is 0.
- R6: In mode 3 (suspend read), a read of a sector whose mask bit is set returns bit 7 = 1 and `array_sel_o` = 0; the activity toggle holds and the sector toggle flips.
- R7: In mode 3, a read of a sector whose mask bit is clear sets `array_sel_o` = 1 and `stat_o` = 8'h00, and neither toggle advances.
- R8: In mode 4 (suspend program) a read returns bit 7 = inverted `prog_data_i[7]` and bit 6 = the activity toggle, which then flips; the sector toggle holds.
- R9: A pulse on `op_start_i` clears both toggles. A read in the same cycle reports both toggles as 0 and does not advance them.
- R10: Outputs change only in the cycle after a read strobe. Mode 0, and any code above 4, gives `array_sel_o` = 1 and `stat_o` = 8'h00 and advances no toggle. Bits 4, 1 and 0 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_start_i | input | 1 | One-cycle pulse when a program or erase begins |
| rd_stb_i | input | 1 | One-cycle read strobe |
| rd_sector_i | input | SECT_W | Sector index of the read address |
| prog_data_i | input | 8 | Datum being programmed |
| mode_i | input | 3 | 0 idle, 1 program, 2 erase, 3 suspend read, 4 suspend program |
| erase_mask_i | input | NUM_SECT | One bit per sector selected for erase |
| timeout_i | input | 1 | Operation exceeded its time limit |
| win_open_i | input | 1 | Sector-erase load window still open |
| stat_o | output | 8 | Registered status byte |
| array_sel_o | output | 1 | Return array data instead of status |

## Verification
The bench runs program reads at several sectors with data whose top bit is 0 and then 1, which tells an inverted bit 7 apart from a true one and shows that the activity toggle ignores the address. Erase reads alternate between sectors inside and outside the mask, which separates the sector toggle from the activity toggle. The window and timeout flags are switched between reads. Suspend-read reads at a masked sector and at an unmasked sector distinguish status from pass-through. Restarts, an idle read and input changes without a strobe show that the toggles clear and that the outputs hold.

// File: rtl/fws_pkg.sv
// Package: shared mode encoding for the write status generator.
// Assumes the controller drives one of the listed codes; others mean idle.
package fws_pkg;
    typedef enum logic [2:0] {
        MD_IDLE  = 3'd0,
        MD_PROG  = 3'd1,
        MD_ERASE = 3'd2,
        MD_SREAD = 3'd3,
        MD_SPROG = 3'd4
    } fws_mode_e;

    localparam int TGL_ACT = 0;   // index of the activity toggle
    localparam int TGL_SEC = 1;   // index of the sector toggle
    localparam int NUM_TGL = 2;
endpackage

// File: rtl/fws_sector_hit.sv
// Module: decides whether the read sector is one marked for erase.
// Assumes rd_sector is below NUM_SECT; an out-of-range index reads as miss.
module fws_sector_hit #(
    parameter int NUM_SECT = 8,
    localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
    input  logic [SECT_W-1:0]   rd_sector,
    input  logic [NUM_SECT-1:0] erase_mask,
    output logic                hit
);
    // Purpose: one-hot compare of the sector index against the mask.
    always_comb begin
        hit = 1'b0;
        for (int s = 0; s < NUM_SECT; s++) begin
            if (rd_sector == SECT_W'(s) && erase_mask[s]) hit = 1'b1;
        end
    end
endmodule

// File: rtl/fws_toggle.sv
// Module: one toggle flip-flop that flips on advance and clears on start.
// Assumes clr has priority over adv.
module fws_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic q
);
    // Purpose: hold, flip or clear the toggle state.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (clr) q <= 1'b0;
        else if (adv) q <= ~q;
    end
endmodule

// File: rtl/fws_compose.sv
// Module: combinational build of the status byte and the pass-through flag.
// Assumes toggle inputs are the values before this read advances them.
module fws_compose
    import fws_pkg::*;
(
    input  fws_mode_e mode,
    input  logic      hit,
    input  logic      d7,
    input  logic      t_act,
    input  logic      t_sec,
    input  logic      timeout,
    input  logic      win_open,
    output logic [7:0] stat,
    output logic       array_sel,
    output logic       adv_act,
    output logic       adv_sec
);
    // Purpose: choose the status bits and toggle advances for each mode.
    always_comb begin
        stat      = 8'h00;
        array_sel = 1'b0;
        adv_act   = 1'b0;
        adv_sec   = 1'b0;
        case (mode)
            MD_PROG, MD_SPROG: begin
                stat[7] = ~d7;
                stat[6] = t_act;
                stat[5] = timeout;
                stat[2] = t_sec;
                adv_act = 1'b1;
            end
            MD_ERASE: begin
                stat[7] = 1'b0;
                stat[6] = t_act;
                stat[5] = timeout;
                stat[3] = ~win_open;
                stat[2] = t_sec;
                adv_act = 1'b1;
                adv_sec = hit;
            end
            MD_SREAD: begin
                if (hit) begin
                    stat[7] = 1'b1;
                    stat[6] = t_act;
                    stat[2] = t_sec;
                    adv_sec = 1'b1;
                end else begin
                    array_sel = 1'b1;
                end
            end
            default: array_sel = 1'b1;
        endcase
    end
endmodule

// File: rtl/flash_wstat.sv
// Module: top of the write status generator. Registers the status byte
// and the pass-through flag on each read strobe and keeps two toggles.
// Assumes op_start is a single-cycle pulse and rd_stb a single-cycle strobe.
module flash_wstat
    import fws_pkg::*;
#(
    parameter int NUM_SECT = 8,
    localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_start_i,
    input  logic                rd_stb_i,
    input  logic [SECT_W-1:0]   rd_sector_i,
    input  logic [7:0]          prog_data_i,
    input  logic [2:0]          mode_i,
    input  logic [NUM_SECT-1:0] erase_mask_i,
    input  logic                timeout_i,
    input  logic                win_open_i,
    output logic [7:0]          stat_o,
    output logic                array_sel_o
);
    logic               hit;
    logic [NUM_TGL-1:0] tgl_q;
    logic [NUM_TGL-1:0] tgl_adv;
    logic [7:0]         stat_c;
    logic               sel_c;
    logic               adv_act, adv_sec;
    logic [7:0]         stat_q;
    logic               sel_q;

    fws_sector_hit #(.NUM_SECT(NUM_SECT)) u_hit (
        .rd_sector (rd_sector_i),
        .erase_mask(erase_mask_i),
        .hit       (hit)
    );

    fws_compose u_comp (
        .mode     (fws_mode_e'(mode_i)),
        .hit      (hit),
        .d7       (prog_data_i[7]),
        .t_act    (op_start_i ? 1'b0 : tgl_q[TGL_ACT]),
        .t_sec    (op_start_i ? 1'b0 : tgl_q[TGL_SEC]),
        .timeout  (timeout_i),
        .win_open (win_open_i),
        .stat     (stat_c),
        .array_sel(sel_c),
        .adv_act  (adv_act),
        .adv_sec  (adv_sec)
    );

    // Purpose: gate each toggle advance with the read strobe.
    always_comb begin
        tgl_adv          = '0;
        tgl_adv[TGL_ACT] = rd_stb_i & adv_act;
        tgl_adv[TGL_SEC] = rd_stb_i & adv_sec;
    end

    for (genvar g = 0; g < NUM_TGL; g++) begin : g_tgl
        fws_toggle u_tgl (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (op_start_i),
            .adv  (tgl_adv[g]),
            .q    (tgl_q[g])
        );
    end

    // Purpose: capture the status byte and pass-through flag on each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 8'h00;
            sel_q  <= 1'b0;
        end else if (rd_stb_i) begin
            stat_q <= stat_c;
            sel_q  <= sel_c;
        end
    end

    assign stat_o      = stat_q;
    assign array_sel_o = sel_q;
endmodule

// File: rtl/flash_wstat_chk.sv
// Module: assertion checker bound to flash_wstat.
// Assumes it sees the two toggle states through the bind connection.
module flash_wstat_chk #(
    parameter int NUM_SECT = 8,
    localparam int SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                op_start_i,
    input logic                rd_stb_i,
    input logic [SECT_W-1:0]   rd_sector_i,
    input logic [7:0]          prog_data_i,
    input logic [2:0]          mode_i,
    input logic [NUM_SECT-1:0] erase_mask_i,
    input logic [7:0]          stat_o,
    input logic                array_sel_o,
    input logic [1:0]          tgl_q
);
    logic sec_in_mask;
    assign sec_in_mask = erase_mask_i[rd_sector_i];

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_i |=> ($stable(stat_o) && $stable(array_sel_o)));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_start_i |=> (tgl_q == 2'b00));

    assert_prog_q7_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && mode_i == 3'd1) |=> (stat_o[7] == ~$past(prog_data_i[7])));

    assert_erase_q7_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && mode_i == 3'd2) |=> (stat_o[7] == 1'b0));

    assert_erase_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && !op_start_i && mode_i == 3'd2) |=> (tgl_q[0] != $past(tgl_q[0])));

    assert_susp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && !op_start_i && mode_i == 3'd3 && sec_in_mask)
        |=> (tgl_q[0] == $past(tgl_q[0]) && stat_o[7] && !array_sel_o));

    assert_susp_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && mode_i == 3'd3 && !sec_in_mask) |=> (array_sel_o && stat_o == 8'h00));
endmodule

bind flash_wstat flash_wstat_chk #(.NUM_SECT(NUM_SECT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_start_i  (op_start_i),
    .rd_stb_i    (rd_stb_i),
    .rd_sector_i (rd_sector_i),
    .prog_data_i (prog_data_i),
    .mode_i      (mode_i),
    .erase_mask_i(erase_mask_i),
    .stat_o      (stat_o),
    .array_sel_o (array_sel_o),
    .tgl_q       (tgl_q)
);

// File: tb/test_flash_wstat.sv
// Bench: scoreboard test of flash_wstat. A driver task pushes expected
// results; a monitor pops and compares one per read strobe.
module test_flash_wstat;
    localparam int NS = 8;
    localparam logic [2:0] M_IDLE = 3'd0, M_PROG = 3'd1, M_ERASE = 3'd2,
                           M_SREAD = 3'd3, M_SPROG = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start = 1'b0;
    logic       rd_stb = 1'b0;
    logic [2:0] rd_sector = '0;
    logic [7:0] prog_data = '0;
    logic [2:0] mode = M_IDLE;
    logic [NS-1:0] mask = '0;
    logic       timeout = 1'b0;
    logic       win_open = 1'b0;
    logic [7:0] stat;
    logic       asel;

    int checks = 0;
    int fails  = 0;
    logic e_act = 1'b0;
    logic e_sec = 1'b0;

    typedef struct {
        logic [7:0] st;
        logic       sel;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    flash_wstat #(.NUM_SECT(NS)) i_flash_wstat (
        .clk(clk), .rst_n(rst_n), .op_start_i(op_start), .rd_stb_i(rd_stb),
        .rd_sector_i(rd_sector), .prog_data_i(prog_data), .mode_i(mode),
        .erase_mask_i(mask), .timeout_i(timeout), .win_open_i(win_open),
        .stat_o(stat), .array_sel_o(asel)
    );

    task automatic check(input string req, input logic [7:0] st_a, input logic sel_a,
                         input logic [7:0] st_e, input logic sel_e);
        checks++;
        if (st_a !== st_e || sel_a !== sel_e) begin
            fails++;
            $display("FAIL %s stat=%h sel=%b expected stat=%h sel=%b",
                     req, st_a, sel_a, st_e, sel_e);
        end
    endtask

    // Driver: compute expected result from the requirements, then strobe.
    task automatic do_read(input logic [2:0] sec, input string req);
        exp_t e;
        logic hit;
        hit = mask[sec];
        e.st = 8'h00; e.sel = 1'b0; e.req = req;
        case (mode)
            M_PROG, M_SPROG: begin
                e.st = {~prog_data[7], e_act, timeout, 2'b00, e_sec, 2'b00};
                e_act = ~e_act;
            end
            M_ERASE: begin
                e.st = {1'b0, e_act, timeout, 1'b0, ~win_open, e_sec, 2'b00};
                e_act = ~e_act;
                if (hit) e_sec = ~e_sec;
            end
            M_SREAD: begin
                if (hit) begin
                    e.st = {1'b1, e_act, 3'b000, e_sec, 2'b00};
                    e_sec = ~e_sec;
                end else e.sel = 1'b1;
            end
            default: e.sel = 1'b1;
        endcase
        sb.push_back(e);
        @(negedge clk);
        rd_sector = sec;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic start_op;
        @(negedge clk);
        op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        e_act = 1'b0;
        e_sec = 1'b0;
    endtask

    // Monitor: one result per strobe, visible just after the edge.
    always @(posedge clk) begin
        if (rd_stb) begin
            #1;
            if (sb.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard empty stat=%h sel=%b expected none", stat, asel);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, stat, asel, e.st, e.sel);
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", stat, asel, 8'h00, 1'b0);

        // R2: program, bit 7 of datum 0 then 1, several sectors
        mode = M_PROG; prog_data = 8'h35; mask = 8'b0000_0110;
        start_op();
        do_read(3'd0, "R2 prog q7 inverted d7=0");
        do_read(3'd1, "R2 prog toggle other sector");
        do_read(3'd7, "R2 prog toggle third read");
        prog_data = 8'hA0;
        do_read(3'd2, "R2 prog q7 inverted d7=1");
        timeout = 1'b1;
        do_read(3'd4, "R4 prog timeout bit");
        timeout = 1'b0;

        // R3/R5: erase, masked versus unmasked reads
        mode = M_ERASE; win_open = 1'b1;
        start_op();
        do_read(3'd1, "R3 erase masked read window open R5");
        do_read(3'd5, "R3 erase unmasked read");
        win_open = 1'b0;
        do_read(3'd2, "R5 erase window closed");
        do_read(3'd6, "R3 erase unmasked again");
        timeout = 1'b1;
        do_read(3'd1, "R4 erase timeout bit");
        timeout = 1'b0;

        // R6/R7: suspend read
        mode = M_SREAD;
        do_read(3'd2, "R6 suspend read masked");
        do_read(3'd1, "R6 suspend read masked again");
        do_read(3'd0, "R7 suspend read unmasked pass-through");
        do_read(3'd2, "R6 masked after pass-through");

        // R8: suspend program
        mode = M_SPROG; prog_data = 8'h80;
        do_read(3'd3, "R8 suspend program first");
        timeout = 1'b1;
        do_read(3'd3, "R8 suspend program toggle R4");
        timeout = 1'b0;
        mode = M_SREAD;
        do_read(3'd0, "R4 suspend read timeout ignored R7");

        // R9: restart clears toggles; read in same cycle as start
        mode = M_ERASE;
        start_op();
        do_read(3'd1, "R9 first read after start");
        @(negedge clk);
        begin
            exp_t e;
            e.st = {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00};
            e.sel = 1'b0; e.req = "R9 read during start";
            sb.push_back(e);
            op_start = 1'b1; rd_stb = 1'b1; rd_sector = 3'd1;
            @(negedge clk);
            op_start = 1'b0; rd_stb = 1'b0;
            e_act = 1'b0; e_sec = 1'b0;
        end
        do_read(3'd1, "R9 toggles not advanced by start read");

        // R10: hold without strobe, idle and undefined modes
        @(negedge clk);
        begin
            logic [7:0] held;
            held = stat;
            mode = M_PROG; prog_data = 8'h00; timeout = 1'b1; rd_sector = 3'd7;
            repeat (3) @(negedge clk);
            check("R10 hold without strobe", stat, asel, held, 1'b0);
            timeout = 1'b0;
        end
        mode = M_IDLE;
        do_read(3'd1, "R10 idle pass-through");
        mode = 3'd6;
        do_read(3'd2, "R10 undefined mode as idle");
        mode = M_ERASE;
        do_read(3'd1, "R10 idle did not advance toggles");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard left=%0d expected 0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule